// File: doc/BRIEF.md
# Receive FIFO Hysteresis Flow Control

This block decides when the far end of a serial link must pause and when it may resume sending. It compares the occupancy count of a 64-entry receive FIFO against two programmable thresholds. One threshold pauses the sender and the other releases it. The gap between the two gives hysteresis, so the flow-control signal does not toggle on every byte that enters or leaves the FIFO.

The thresholds live in an 8-bit control register. Each 4-bit field counts in units of four bytes. A host write reaches the register only when two separate permission inputs are both high. An elaboration parameter chooses how the decision is presented. In line mode the block drives an active-low ready-to-send line. In character mode it issues one-cycle requests that a transmitter turns into a pause or resume character. The FIFO itself, character serialisation, baud timing and bus decoding are all outside the block.

Top module: `rx_flow_hyst`

## Requirements
- R1: During and after reset, the control register reads 0x00, halt is 0, rts_n is 1, and both character requests are 0.
- R2: A write with wr_en high updates the register on the next clock edge only when enh_en and acc_en are both 1. In every other case the register keeps its value.
- R3: Register bits 3:0 set the pause level and bits 7:4 set the release level. Each level in bytes is its field value times 4, so 0x2B means pause at 44 and release at 8.
- R4: With flow_en high, a count at or above the pause level sets halt one cycle later.
- R5: Once set, halt stays high while the count is above the release level and below the pause level. It clears one cycle after the count is at or below the release level.
- R6: With flow_en low, halt clears one cycle later and the resumed state is kept. After flow_en is raised again, a count between the two levels leaves halt at 0.
- R7: When the pause level is not above the release level, the pause condition wins in any cycle where both conditions hold. With both fields zero, any count sets halt.
- R8: In line mode, rts_n is the inverse of halt and both character requests stay 0.
- R9: In character mode, xoff_req pulses for one cycle in the same cycle that halt rises, and xon_req pulses for one cycle in the same cycle that halt falls. rts_n stays 1.
- R10: A full-FIFO count of 64 is handled: it is at or above the highest pause level of 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| enh_en | input | 1 | Enhanced-feature permission |
| acc_en | input | 1 | Register-access permission |
| flow_en | input | 1 | Flow control enable |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| ctrl_q | output | 8 | Current threshold register contents |
| halt | output | 1 | Pause decision, 1 while the sender should pause |
| rts_n | output | 1 | Active-low ready-to-send (line mode) |
| xoff_req | output | 1 | One-cycle pause-character request (character mode) |
| xon_req | output | 1 | One-cycle resume-character request (character mode) |

## Verification
The count is swept up through the pause level and back down through the release level. Stops inside the band show that halt holds its previous value instead of following a single threshold, and stops exactly on each level separate "at or above" and "at or below" from strict comparisons. An inverted threshold pair and an all-zero register show which condition has priority. A full count of 64 checks that the 7-bit comparison does not wrap. Writes made with each permission combination separate a single-bit gate from the required pair. Both presentation modes run side by side on the same stimulus, which shows that line and character outputs follow the same edges.

// File: rtl/fcx_pkg.sv
package fcx_pkg;

   typedef enum logic {
      SIG_LINE = 1'b0,
      SIG_CHAR = 1'b1
   } sig_mode_e;

   typedef struct packed {
      logic [3:0] release_f;
      logic [3:0] pause_f;
   } thr_reg_t;

endpackage

// File: rtl/fcx_ctrl_reg.sv
module fcx_ctrl_reg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             enh_en,
   input  logic             acc_en,
   output logic [REG_W-1:0] reg_q
);

   logic wr_ok;

   assign wr_ok = wr_en & enh_en & acc_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (wr_ok) begin
         reg_q <= wr_data;
      end
   end

endmodule

// File: rtl/fcx_level_cmp.sv
module fcx_level_cmp #(
   parameter int FIELD_W    = 4,
   parameter int STEP_SHIFT = 2,
   parameter int CNT_W      = 7
) (
   input  logic [FIELD_W-1:0] pause_f,
   input  logic [FIELD_W-1:0] release_f,
   input  logic [CNT_W-1:0]   count,
   output logic               at_pause,
   output logic               at_release
);

   logic [CNT_W-1:0] pause_lvl;
   logic [CNT_W-1:0] release_lvl;

   assign pause_lvl   = CNT_W'(pause_f)   << STEP_SHIFT;
   assign release_lvl = CNT_W'(release_f) << STEP_SHIFT;

   assign at_pause   = (count >= pause_lvl);
   assign at_release = (count <= release_lvl);

endmodule

// File: rtl/fcx_hyst_fsm.sv
module fcx_hyst_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic flow_en,
   input  logic at_pause,
   input  logic at_release,
   output logic halt_q,
   output logic rise_q,
   output logic fall_q
);

   logic halt_nxt;

   always_comb begin
      if (!flow_en) begin
         halt_nxt = 1'b0;
      end else if (at_pause) begin
         halt_nxt = 1'b1;
      end else if (at_release) begin
         halt_nxt = 1'b0;
      end else begin
         halt_nxt = halt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         halt_q <= halt_nxt;
         rise_q <= halt_nxt & ~halt_q;
         fall_q <= ~halt_nxt & halt_q;
      end
   end

endmodule

// File: rtl/fcx_signal_out.sv
module fcx_signal_out #(
   parameter fcx_pkg::sig_mode_e SIG_MODE = fcx_pkg::SIG_LINE
) (
   input  logic halt_q,
   input  logic rise_q,
   input  logic fall_q,
   output logic rts_n,
   output logic xoff_req,
   output logic xon_req
);

   generate
      if (SIG_MODE == fcx_pkg::SIG_LINE) begin : g_line
         assign rts_n    = ~halt_q;
         assign xoff_req = 1'b0;
         assign xon_req  = 1'b0;
         logic unused_edges;
         assign unused_edges = rise_q ^ fall_q;
      end else begin : g_char
         assign rts_n    = 1'b1;
         assign xoff_req = rise_q;
         assign xon_req  = fall_q;
         logic unused_lvl;
         assign unused_lvl = halt_q;
      end
   endgenerate

endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst #(
   parameter int                 DEPTH      = 64,
   parameter int                 FIELD_W    = 4,
   parameter int                 STEP_SHIFT = 2,
   parameter int                 CNT_W      = 7,
   parameter fcx_pkg::sig_mode_e SIG_MODE   = fcx_pkg::SIG_LINE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2*FIELD_W-1:0]   wr_data,
   input  logic                   enh_en,
   input  logic                   acc_en,
   input  logic                   flow_en,
   input  logic [CNT_W-1:0]       rx_count,
   output logic [2*FIELD_W-1:0]   ctrl_q,
   output logic                   halt,
   output logic                   rts_n,
   output logic                   xoff_req,
   output logic                   xon_req
);

   localparam int REG_W   = 2 * FIELD_W;
   localparam int MAX_LVL = ((1 << FIELD_W) - 1) << STEP_SHIFT;

   generate
      if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
         $error("CNT_W too narrow for DEPTH");
      end
      if (MAX_LVL > DEPTH) begin : g_bad_lvl
         $error("threshold range exceeds DEPTH");
      end
      if (FIELD_W + STEP_SHIFT > CNT_W) begin : g_bad_fld
         $error("scaled field does not fit in CNT_W");
      end
   endgenerate

   logic at_pause, at_release;
   logic halt_q, rise_q, fall_q;

   fcx_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .enh_en  (enh_en),
      .acc_en  (acc_en),
      .reg_q   (ctrl_q)
   );

   fcx_level_cmp #(
      .FIELD_W    (FIELD_W),
      .STEP_SHIFT (STEP_SHIFT),
      .CNT_W      (CNT_W)
   ) u_cmp (
      .pause_f    (ctrl_q[FIELD_W-1:0]),
      .release_f  (ctrl_q[REG_W-1:FIELD_W]),
      .count      (rx_count),
      .at_pause   (at_pause),
      .at_release (at_release)
   );

   fcx_hyst_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .flow_en    (flow_en),
      .at_pause   (at_pause),
      .at_release (at_release),
      .halt_q     (halt_q),
      .rise_q     (rise_q),
      .fall_q     (fall_q)
   );

   fcx_signal_out #(.SIG_MODE(SIG_MODE)) u_out (
      .halt_q   (halt_q),
      .rise_q   (rise_q),
      .fall_q   (fall_q),
      .rts_n    (rts_n),
      .xoff_req (xoff_req),
      .xon_req  (xon_req)
   );

   assign halt = halt_q;

endmodule

// File: rtl/rx_flow_hyst_chk.sv
module rx_flow_hyst_chk #(
   parameter int                 FIELD_W    = 4,
   parameter int                 STEP_SHIFT = 2,
   parameter int                 CNT_W      = 7,
   parameter fcx_pkg::sig_mode_e SIG_MODE   = fcx_pkg::SIG_LINE
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 enh_en,
   input logic                 acc_en,
   input logic                 flow_en,
   input logic [CNT_W-1:0]     rx_count,
   input logic [2*FIELD_W-1:0] ctrl_q,
   input logic                 halt,
   input logic                 rts_n,
   input logic                 xoff_req,
   input logic                 xon_req
);

   logic [CNT_W-1:0] p_lvl, r_lvl;
   assign p_lvl = CNT_W'(ctrl_q[FIELD_W-1:0]) << STEP_SHIFT;
   assign r_lvl = CNT_W'(ctrl_q[2*FIELD_W-1:FIELD_W]) << STEP_SHIFT;

   a_r2_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && enh_en && acc_en) |=> $stable(ctrl_q));

   a_r4_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && rx_count >= p_lvl) |=> halt);

   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && rx_count < p_lvl && rx_count <= r_lvl) |=> !halt);

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && rx_count < p_lvl && rx_count > r_lvl) |=> $stable(halt));

   a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !flow_en |=> !halt);

   generate
      if (SIG_MODE == fcx_pkg::SIG_LINE) begin : g_line_chk
         a_r8_line: assert property (@(posedge clk) disable iff (!rst_n)
            (rts_n == !halt) && !xoff_req && !xon_req);
      end else begin : g_char_chk
         a_r9_xoff: assert property (@(posedge clk) disable iff (!rst_n)
            xoff_req == $rose(halt));
         a_r9_xon: assert property (@(posedge clk) disable iff (!rst_n)
            xon_req == $fell(halt));
         a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({xoff_req, xon_req}) && rts_n);
      end
   endgenerate

endmodule

bind rx_flow_hyst rx_flow_hyst_chk #(
   .FIELD_W    (FIELD_W),
   .STEP_SHIFT (STEP_SHIFT),
   .CNT_W      (CNT_W),
   .SIG_MODE   (SIG_MODE)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .enh_en   (enh_en),
   .acc_en   (acc_en),
   .flow_en  (flow_en),
   .rx_count (rx_count),
   .ctrl_q   (ctrl_q),
   .halt     (halt),
   .rts_n    (rts_n),
   .xoff_req (xoff_req),
   .xon_req  (xon_req)
);

// File: tb/rx_flow_hyst_tb_top.sv
`timescale 1ns/1ps
module rx_flow_hyst_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       enh_en = 1'b0;
   logic       acc_en = 1'b0;
   logic       flow_en = 1'b0;
   logic [6:0] rx_count = '0;

   logic [7:0] ctrl_q, ctrl_c;
   logic halt, rts_n, xoff_req, xon_req;
   logic halt_c, rts_c, xoff_c, xon_c;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_flow_hyst dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .enh_en(enh_en), .acc_en(acc_en), .flow_en(flow_en), .rx_count(rx_count),
      .ctrl_q(ctrl_q), .halt(halt), .rts_n(rts_n),
      .xoff_req(xoff_req), .xon_req(xon_req)
   );

   rx_flow_hyst #(.SIG_MODE(fcx_pkg::SIG_CHAR)) dut_c (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .enh_en(enh_en), .acc_en(acc_en), .flow_en(flow_en), .rx_count(rx_count),
      .ctrl_q(ctrl_c), .halt(halt_c), .rts_n(rts_c),
      .xoff_req(xoff_c), .xon_req(xon_c)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FIAL-free marker"); 
      end
   endtask

   task automatic cmp(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // apply inputs before the next edge, then sample after it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] d, input logic e, input logic a);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; enh_en = e; acc_en = a;
      step();
      @(negedge clk);
      wr_en = 1'b0; enh_en = 1'b0; acc_en = 1'b0;
   endtask

   task automatic cnt(input int c);
      @(negedge clk);
      rx_count = 7'(c);
      step();
   endtask

   task automatic line_out(input string req, input int h);
      cmp({req, " halt"}, halt, h);
      cmp({req, " rts_n"}, rts_n, !h);
      cmp({req, " char halt"}, halt_c, h);
   endtask

   task automatic t_reset();
      cmp("R1 ctrl", ctrl_q, 0);
      cmp("R1 halt", halt, 0);
      cmp("R1 rts_n", rts_n, 1);
      cmp("R1 xoff", xoff_c, 0);
      cmp("R1 xon", xon_c, 0);
   endtask

   task automatic t_write_gate();
      wr(8'h2B, 1'b1, 1'b0); cmp("R2 enh only", ctrl_q, 0);
      wr(8'h2B, 1'b0, 1'b1); cmp("R2 acc only", ctrl_q, 0);
      wr(8'h2B, 1'b0, 1'b0); cmp("R2 neither", ctrl_q, 0);
      wr(8'h2B, 1'b1, 1'b1); cmp("R2 both", ctrl_q, 8'h2B);
      cmp("R2 both char inst", ctrl_c, 8'h2B);
   endtask

   task automatic t_hysteresis();
      @(negedge clk); flow_en = 1'b1;
      cnt(10); line_out("R5 band from resumed", 0);
      cnt(43); line_out("R3 below pause 44", 0);
      cnt(44); line_out("R4 at pause 44", 1);
      cmp("R9 xoff pulse", xoff_c, 1);
      cmp("R9 xon quiet", xon_c, 0);
      cmp("R8 line reqs", xoff_req | xon_req, 0);
      cmp("R9 rts_n char", rts_c, 1);
      cnt(20); line_out("R5 hold in band", 1);
      cmp("R9 xoff one cycle", xoff_c, 0);
      cnt(9);  line_out("R5 above release 8", 1);
      cnt(8);  line_out("R5 at release 8", 0);
      cmp("R9 xon pulse", xon_c, 1);
      cnt(30); line_out("R5 band after release", 0);
      cmp("R9 xon one cycle", xon_c, 0);
   endtask

   task automatic t_full();
      wr(8'h1F, 1'b1, 1'b1);
      cnt(59); line_out("R10 below 60", 0);
      cnt(64); line_out("R10 full count", 1);
      cnt(5);  line_out("R10 hold above 4", 1);
      cnt(4);  line_out("R10 release at 4", 0);
   endtask

   task automatic t_disable();
      cnt(64); line_out("R6 set before disable", 1);
      @(negedge clk); flow_en = 1'b0;
      step(); line_out("R6 disabled", 0);
      cmp("R6 xon on disable", xon_c, 1);
      step(); line_out("R6 stays off at 64", 0);
      @(negedge clk); flow_en = 1'b1; rx_count = 7'd30;
      step(); line_out("R6 resumed state kept", 0);
   endtask

   task automatic t_inverted();
      wr(8'h84, 1'b1, 1'b1);
      cnt(20); line_out("R7 pause wins", 1);
      cnt(10); line_out("R7 release below both", 0);
      wr(8'h00, 1'b1, 1'b1);
      cnt(0);  line_out("R7 zero fields", 1);
      @(negedge clk); flow_en = 1'b0;
      step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      step();
      t_reset();
      t_write_gate();
      t_hysteresis();
      t_full();
      t_disable();
      t_inverted();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule